// File: doc/BRIEF.md
# Load/Store Address Generator

This block forms the memory address for one load or store from a base register value and an unsigned immediate offset. A direction control picks whether the offset is added to the base or subtracted from it. A two-bit indexing mode then decides two things: which value goes to memory, and whether the adjusted base is handed back for the register file to store.

Each request is a single-cycle strobe carrying the base, offset, direction and mode. One clock later the block presents the access address, the candidate write-back value and a write-back enable, together with a one-cycle done pulse.

Register file access, the memory transaction and instruction decoding belong to neighbouring blocks. Requests may arrive on every cycle, back to back.

Top module: `ldst_addr_gen`

## Requirements
- R1: When `ofs_sub` is 0 the combined value is base plus the zero-extended offset; when it is 1 it is base minus the zero-extended offset.
- R2: With `idx_mode` = 2'b00 (plain offset), `acc_addr` equals the combined value and `wb_en` stays 0. `wb_value` still carries the combined value.
- R3: With `idx_mode` = 2'b01 (pre-index), `acc_addr` and `wb_value` both equal the combined value and `wb_en` is 1.
- R4: With `idx_mode` = 2'b10 (post-index), `acc_addr` equals the unmodified base, `wb_value` equals the combined value and `wb_en` is 1.
- R5: `idx_mode` = 2'b11 behaves exactly as plain offset mode.
- R6: Address arithmetic wraps modulo 2^32 and no overflow or underflow indication exists.
- R7: `wb_en` is high only in a cycle where `done` is high.
- R8: `done` is high exactly in the cycle after a cycle with `req` high. After a cycle without a request, `done` and `wb_en` are 0 and `acc_addr` and `wb_value` keep their previous values.
- R9: While `rst_n` is low at a rising clock edge, all outputs are cleared to 0 at that edge, whatever the request inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| req | input | 1 | Request strobe, one cycle per access |
| base_val | input | 32 | Base register value |
| imm_ofs | input | 12 | Unsigned immediate offset |
| ofs_sub | input | 1 | 0 adds the offset, 1 subtracts it |
| idx_mode | input | 2 | 00 offset, 01 pre-index, 10 post-index, 11 treated as offset |
| acc_addr | output | 32 | Address for the memory access |
| wb_en | output | 1 | Base register write-back enable |
| wb_value | output | 32 | Value to write back to the base register |
| done | output | 1 | One-cycle pulse marking valid results |

## Verification
The access address and the base write-back come out in the same cycle. In post-index mode they must carry different values, and in pre-index mode the same value. The bench provokes this with back-to-back requests that switch mode, direction and wrap-around on every cycle. It checks address, enable and write-back value together against its table on each done pulse. It also confirms that a plain-offset request placed between two write-back requests never leaves the enable raised.

// File: rtl/ldst_addr_pkg.sv
package ldst_addr_pkg;

    typedef enum logic [1:0] {
        IX_OFFSET = 2'b00,
        IX_PRE    = 2'b01,
        IX_POST   = 2'b10,
        IX_ALIAS  = 2'b11
    } ix_mode_e;

endpackage

// File: rtl/ldst_offset_alu.sv
module ldst_offset_alu #(
    parameter int ADDR_W = 32,
    parameter int OFS_W  = 12
) (
    input  logic [ADDR_W-1:0] base_i,
    input  logic [OFS_W-1:0]  ofs_i,
    input  logic              sub_i,
    output logic [ADDR_W-1:0] sum_o
);

    logic [ADDR_W-1:0] ofs_ext;

    generate
        if (OFS_W < ADDR_W) begin : g_zext
            localparam int PAD_W = ADDR_W - OFS_W;
            assign ofs_ext = {{PAD_W{1'b0}}, ofs_i};
        end else begin : g_trunc
            assign ofs_ext = ofs_i[ADDR_W-1:0];
        end
    endgenerate

    // Modulo 2^ADDR_W arithmetic; the carry out is discarded.
    always_comb begin
        if (sub_i) begin
            sum_o = base_i - ofs_ext;
        end else begin
            sum_o = base_i + ofs_ext;
        end
    end

endmodule

// File: rtl/ldst_mode_sel.sv
module ldst_mode_sel
    import ldst_addr_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [1:0]        mode_i,
    input  logic [ADDR_W-1:0] base_i,
    input  logic [ADDR_W-1:0] sum_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic              wb_o
);

    ix_mode_e mode;
    assign mode = ix_mode_e'(mode_i);

    always_comb begin
        addr_o = sum_i;
        wb_o   = 1'b0;
        unique case (mode)
            IX_PRE: begin
                addr_o = sum_i;
                wb_o   = 1'b1;
            end
            IX_POST: begin
                addr_o = base_i;
                wb_o   = 1'b1;
            end
            IX_OFFSET, IX_ALIAS: begin
                addr_o = sum_i;
                wb_o   = 1'b0;
            end
            default: begin
                addr_o = sum_i;
                wb_o   = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/ldst_addr_gen.sv
module ldst_addr_gen #(
    parameter int ADDR_W = 32,
    parameter int OFS_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic [ADDR_W-1:0] base_val,
    input  logic [OFS_W-1:0]  imm_ofs,
    input  logic              ofs_sub,
    input  logic [1:0]        idx_mode,
    output logic [ADDR_W-1:0] acc_addr,
    output logic              wb_en,
    output logic [ADDR_W-1:0] wb_value,
    output logic              done
);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [ADDR_W-1:0] wbv;
        logic              wbe;
        logic              dn;
    } out_st_t;

    out_st_t st_d, st_q;

    logic [ADDR_W-1:0] sum_w;
    logic [ADDR_W-1:0] addr_w;
    logic              wbe_w;

    ldst_offset_alu #(
        .ADDR_W(ADDR_W),
        .OFS_W (OFS_W)
    ) u_alu (
        .base_i(base_val),
        .ofs_i (imm_ofs),
        .sub_i (ofs_sub),
        .sum_o (sum_w)
    );

    ldst_mode_sel #(
        .ADDR_W(ADDR_W)
    ) u_sel (
        .mode_i(idx_mode),
        .base_i(base_val),
        .sum_i (sum_w),
        .addr_o(addr_w),
        .wb_o  (wbe_w)
    );

    always_comb begin
        st_d     = st_q;
        st_d.dn  = req;
        st_d.wbe = 1'b0;
        if (req) begin
            st_d.addr = addr_w;
            st_d.wbv  = sum_w;
            st_d.wbe  = wbe_w;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign acc_addr = st_q.addr;
    assign wb_value = st_q.wbv;
    assign wb_en    = st_q.wbe;
    assign done     = st_q.dn;

    // Assertions
    p_done_after_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> done);
    p_idle_no_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !req |=> (!done && !wb_en));
    p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !req |=> ($stable(acc_addr) && $stable(wb_value)));
    p_wb_with_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |-> done);
    p_offset_no_wb_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req && (idx_mode == 2'b00 || idx_mode == 2'b11)) |=> !wb_en);
    p_pre_same_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req && idx_mode == 2'b01) |=> (wb_en && acc_addr == wb_value));
    p_post_base_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req && idx_mode == 2'b10) |=> (wb_en && acc_addr == $past(base_val)));
    p_reset_clear_r9: assert property (@(posedge clk)
        !rst_n |=> (!done && !wb_en && acc_addr == '0 && wb_value == '0));

endmodule

// File: tb/ldst_addr_gen_test.sv
module ldst_addr_gen_test;

    localparam int CLK_PERIOD = 10;
    localparam int NV = 9;

    typedef struct packed {
        logic [1:0]  mode;
        logic        sub;
        logic [31:0] base;
        logic [11:0] ofs;
        logic [31:0] e_addr;
        logic        e_wbe;
        logic [31:0] e_wbv;
    } vec_t;

    localparam vec_t VECS [NV] = '{
        '{2'b00, 1'b0, 32'h0000_0100, 12'h00C, 32'h0000_010C, 1'b0, 32'h0000_010C}, // R2
        '{2'b00, 1'b1, 32'h0000_0100, 12'h010, 32'h0000_00F0, 1'b0, 32'h0000_00F0}, // R1
        '{2'b01, 1'b0, 32'h0000_2000, 12'h7FF, 32'h0000_27FF, 1'b1, 32'h0000_27FF}, // R3
        '{2'b01, 1'b1, 32'h0000_1000, 12'hFFF, 32'h0000_0001, 1'b1, 32'h0000_0001}, // R3
        '{2'b10, 1'b0, 32'h0000_4000, 12'h020, 32'h0000_4000, 1'b1, 32'h0000_4020}, // R4
        '{2'b10, 1'b1, 32'h0000_0080, 12'h004, 32'h0000_0080, 1'b1, 32'h0000_007C}, // R4
        '{2'b11, 1'b0, 32'h0000_0500, 12'h008, 32'h0000_0508, 1'b0, 32'h0000_0508}, // R5
        '{2'b01, 1'b0, 32'hFFFF_FFF0, 12'h020, 32'h0000_0010, 1'b1, 32'h0000_0010}, // R6
        '{2'b10, 1'b1, 32'h0000_0004, 12'h008, 32'h0000_0004, 1'b1, 32'hFFFF_FFFC}  // R6
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req;
    logic [31:0] base_val;
    logic [11:0] imm_ofs;
    logic        ofs_sub;
    logic [1:0]  idx_mode;
    logic [31:0] acc_addr;
    logic        wb_en;
    logic [31:0] wb_value;
    logic        done;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ldst_addr_gen uut (
        .clk(clk), .rst_n(rst_n), .req(req), .base_val(base_val),
        .imm_ofs(imm_ofs), .ofs_sub(ofs_sub), .idx_mode(idx_mode),
        .acc_addr(acc_addr), .wb_en(wb_en), .wb_value(wb_value), .done(done)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic r, input logic [1:0] m, input logic s,
                         input logic [31:0] b, input logic [11:0] o);
        req = r; idx_mode = m; ofs_sub = s; base_val = b; imm_ofs = o;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        rst_n = 1'b0;
        drive(1'b1, 2'b01, 1'b0, 32'h1234_0000, 12'h111);
        repeat (3) @(negedge clk);
        check("R9 reset done", {31'd0, done}, 32'd0);
        check("R9 reset wb_en", {31'd0, wb_en}, 32'd0);
        check("R9 reset addr", acc_addr, 32'd0);
        check("R9 reset wbv", wb_value, 32'd0);
        drive(1'b0, 2'b00, 1'b0, 32'd0, 12'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R8 idle done", {31'd0, done}, 32'd0);

        // Table walk, back-to-back requests
        drive(1'b1, VECS[0].mode, VECS[0].sub, VECS[0].base, VECS[0].ofs);
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            if (i + 1 < NV)
                drive(1'b1, VECS[i+1].mode, VECS[i+1].sub, VECS[i+1].base, VECS[i+1].ofs);
            else
                drive(1'b0, 2'b00, 1'b0, 32'hDEAD_BEEF, 12'hABC);
            check($sformatf("R8 done vec%0d", i), {31'd0, done}, 32'd1);
            check($sformatf("R1-mode addr vec%0d (R2 R3 R4 R5 R6)", i), acc_addr, VECS[i].e_addr);
            check($sformatf("R7 wb_en vec%0d", i), {31'd0, wb_en}, {31'd0, VECS[i].e_wbe});
            check($sformatf("wbv vec%0d (R3 R4 R6)", i), wb_value, VECS[i].e_wbv);
        end

        // R8: no request -> no done, outputs held
        @(negedge clk);
        check("R8 no-req done", {31'd0, done}, 32'd0);
        check("R8 no-req wb_en", {31'd0, wb_en}, 32'd0);
        check("R8 hold addr", acc_addr, VECS[NV-1].e_addr);
        check("R8 hold wbv", wb_value, VECS[NV-1].e_wbv);

        // R2: offset between write-back requests drops wb_en
        drive(1'b1, 2'b10, 1'b0, 32'h0000_0200, 12'h010);
        @(negedge clk);
        drive(1'b1, 2'b00, 1'b0, 32'h0000_0300, 12'h004);
        check("R4 post addr", acc_addr, 32'h0000_0200);
        @(negedge clk);
        drive(1'b0, 2'b00, 1'b0, 32'd0, 12'd0);
        check("R2 offset wb_en low", {31'd0, wb_en}, 32'd0);
        check("R2 offset addr", acc_addr, 32'h0000_0304);

        // R9: reset mid-stream clears
        drive(1'b1, 2'b01, 1'b0, 32'h0000_0800, 12'h001);
        @(negedge clk);
        check("R3 pre wb_en", {31'd0, wb_en}, 32'd1);
        rst_n = 1'b0;
        @(negedge clk);
        check("R9 mid reset done", {31'd0, done}, 32'd0);
        check("R9 mid reset addr", acc_addr, 32'd0);
        check("R9 mid reset wb_en", {31'd0, wb_en}, 32'd0);
        rst_n = 1'b1;
        drive(1'b0, 2'b00, 1'b0, 32'd0, 12'd0);
        @(negedge clk);
        finish_run();
    end

endmodule